// File: doc/BRIEF.md
# Reference-Synchronized Clock Error Counter

This block measures how far a local clock drifts from a periodic reference event, such as a start-of-frame marker that arrives once per millisecond. One counter does the measuring. Each reference pulse loads a programmable reload value into it, and the counter then steps down once per local clock tick. When it passes zero it turns around and steps up. When the next reference pulse arrives, the counting direction gives the sign of the error and the counter value gives its size. The counter then reloads and starts again. With a 48 MHz local clock and 1 ms references, the nominal reload is 48000.

Each capture produces a registered result: the error magnitude, a fast flag, an exact-match flag and a warning. The warning is set when the magnitude is above a programmable limit. A one-cycle valid strobe marks each new result. The up-count saturates instead of wrapping. If the counter reaches saturation, a sticky flag reports that a reference event was missed. The block makes no trimming decision. A controller downstream reads the captured results and acts on them.

Top module: `clk_err_meter`

## Requirements
- R1: After a synchronous reset, err_mag is 0, err_fast, err_match, err_valid, err_warn and miss_flag are all 0, and the counter is idle.
- R2: The first sync_pulse after reset only starts counting. It produces no err_valid strobe.
- R3: Let the reload loaded at the previous pulse be R, and let the current pulse come N clock edges after it. If N < R, the capture reports slow: err_fast=0, err_match=0, err_mag=R-N.
- R4: If N > R, the capture reports fast: err_fast=1, err_match=0, err_mag=N-R. This holds until saturation (R8).
- R5: If N == R, the capture reports an exact match: err_match=1, err_fast=0, err_mag=0.
- R6: err_valid is high for exactly the one cycle after the capturing clock edge, unless another pulse follows at once. The captured fields hold their values until the next capture.
- R7: reload_val is sampled at the pulse that starts an interval. A change to reload_val during an interval affects only the following interval.
- R8: The up-count saturates at 2^CNT_W-1 and does not wrap. A fast error of 2^CNT_W-1 or more is reported as 2^CNT_W-1.
- R9: miss_flag goes high once the up-count reaches saturation. It stays high through later pulses until reset.
- R10: err_warn is 1 exactly when the captured err_mag is strictly greater than err_limit. err_limit is sampled at the capturing pulse, and err_warn holds with the other captured fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock being measured |
| rst | input | 1 | Synchronous active-high reset |
| sync_pulse | input | 1 | Single-cycle reference event |
| reload_val | input | CNT_W | Reload value loaded at each pulse |
| err_limit | input | CNT_W | Magnitude threshold for err_warn |
| err_mag | output | CNT_W | Captured error magnitude |
| err_fast | output | 1 | 1 = local clock ahead of reference (fast), 0 = behind or exact |
| err_match | output | 1 | 1 = error exactly zero |
| err_valid | output | 1 | One-cycle strobe for a new capture |
| err_warn | output | 1 | Captured magnitude exceeds err_limit |
| miss_flag | output | 1 | Sticky: counter saturated, reference missed |

## Verification
The hardest condition to reach from the ports is the saturated up-count and the sticky miss flag. A reference gap longer than the reload plus the full counter range is needed, which would mean tens of thousands of idle cycles at full width. The bench therefore builds the block with an 8-bit counter. It sweeps every pulse spacing from back-to-back up to twenty ticks past the reload, for several reload values, and computes each expected error arithmetically. At the end it allows a single long gap to force saturation, then checks that the miss flag stays set through the next pulse.

// File: rtl/clk_err_pkg.sv
package clk_err_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    typedef struct packed {
        logic fast;
        logic match;
    } err_sign_t;

    function automatic err_sign_t classify(input cnt_dir_e dir, input logic is_zero);
        err_sign_t s;
        s.fast  = (dir == DIR_UP);
        s.match = (dir == DIR_DOWN) && is_zero;
        return s;
    endfunction

endpackage

// File: rtl/ce_updown_counter.sv
module ce_updown_counter
    import clk_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_pulse,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] step_cnt,
    output cnt_dir_e         step_dir,
    output logic             armed,
    output logic             sat_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    cnt_dir_e         dir_q;
    logic             armed_q;

    // Value the counter would take on this edge without a pulse
    always_comb begin
        step_cnt = cnt_q;
        step_dir = dir_q;
        if (dir_q == DIR_DOWN) begin
            if (cnt_q == '0) begin
                step_cnt = CNT_ONE;
                step_dir = DIR_UP;
            end else begin
                step_cnt = cnt_q - CNT_ONE;
            end
        end else if (cnt_q != CNT_MAX) begin
            step_cnt = cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            dir_q   <= DIR_UP;
            armed_q <= 1'b0;
        end else if (sync_pulse) begin
            cnt_q   <= reload_val;
            dir_q   <= DIR_DOWN;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            cnt_q <= step_cnt;
            dir_q <= step_dir;
        end
    end

    assign armed   = armed_q;
    assign sat_hit = armed_q && (dir_q == DIR_UP) && (cnt_q == CNT_MAX);

    assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && dir_q == DIR_DOWN && cnt_q != '0 && !sync_pulse)
        |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> (cnt_q == $past(reload_val) && dir_q == DIR_DOWN && armed_q));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (armed_q && dir_q == DIR_UP && cnt_q == CNT_MAX && !sync_pulse)
        |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ce_capture.sv
module ce_capture
    import clk_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] step_cnt,
    input  cnt_dir_e         step_dir,
    input  logic [CNT_W-1:0] err_limit,
    output logic [CNT_W-1:0] mag,
    output logic             fast,
    output logic             match,
    output logic             valid,
    output logic             warn
);
    logic [CNT_W-1:0] mag_q;
    err_sign_t        sign_q;
    logic             valid_q;
    logic             warn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q   <= '0;
            sign_q  <= '0;
            valid_q <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            valid_q <= cap_en;
            if (cap_en) begin
                mag_q  <= step_cnt;
                sign_q <= classify(step_dir, step_cnt == '0);
                warn_q <= (step_cnt > err_limit);
            end
        end
    end

    assign mag   = mag_q;
    assign fast  = sign_q.fast;
    assign match = sign_q.match;
    assign valid = valid_q;
    assign warn  = warn_q;

    assert_strobe_src_R6: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(cap_en));

    assert_sign_excl_R5: assert property (@(posedge clk) disable iff (rst)
        sign_q.match |-> (!sign_q.fast && mag_q == '0));

    assert_warn_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        warn_q |-> (mag_q != '0));

endmodule

// File: rtl/ce_miss_latch.sv
module ce_miss_latch (
    input  logic clk,
    input  logic rst,
    input  logic sat_hit,
    output logic miss
);
    logic miss_q;

    always_ff @(posedge clk) begin
        if (rst)          miss_q <= 1'b0;
        else if (sat_hit) miss_q <= 1'b1;
    end

    assign miss = miss_q;

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        miss_q |=> miss_q);

endmodule

// File: rtl/clk_err_meter.sv
module clk_err_meter
    import clk_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_pulse,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] err_limit,
    output logic [CNT_W-1:0] err_mag,
    output logic             err_fast,
    output logic             err_match,
    output logic             err_valid,
    output logic             err_warn,
    output logic             miss_flag
);
    logic [CNT_W-1:0] step_cnt;
    cnt_dir_e         step_dir;
    logic             armed;
    logic             sat_hit;

    ce_updown_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .sync_pulse (sync_pulse),
        .reload_val (reload_val),
        .step_cnt   (step_cnt),
        .step_dir   (step_dir),
        .armed      (armed),
        .sat_hit    (sat_hit)
    );

    ce_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (sync_pulse && armed),
        .step_cnt  (step_cnt),
        .step_dir  (step_dir),
        .err_limit (err_limit),
        .mag       (err_mag),
        .fast      (err_fast),
        .match     (err_match),
        .valid     (err_valid),
        .warn      (err_warn)
    );

    ce_miss_latch u_miss (
        .clk     (clk),
        .rst     (rst),
        .sat_hit (sat_hit),
        .miss    (miss_flag)
    );

    assert_first_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (sync_pulse && !armed) |=> !err_valid);

endmodule

// File: tb/sim_clk_err_meter.sv
module sim_clk_err_meter;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync_pulse = 1'b0;
    logic [W-1:0] reload_val = '0;
    logic [W-1:0] err_limit = '0;
    logic [W-1:0] err_mag;
    logic         err_fast, err_match, err_valid, err_warn, miss_flag;

    int total = 0;
    int bad   = 0;
    int r_prev = 0;
    int last_mag = 0;
    bit have_last = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clk_err_meter #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .sync_pulse(sync_pulse),
        .reload_val(reload_val), .err_limit(err_limit),
        .err_mag(err_mag), .err_fast(err_fast), .err_match(err_match),
        .err_valid(err_valid), .err_warn(err_warn), .miss_flag(miss_flag)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Called at the negedge right after a pulse edge; next pulse lands n edges later
    task automatic measure(input int n, input int lim);
        int d, emag;
        err_limit  = W'(lim);
        sync_pulse = 1'b0;
        for (int i = 0; i < n - 1; i++) begin
            @(negedge clk);
            if (i == 0 && have_last) begin
                chk("R6 strobe dropped", int'(err_valid), 0);
                chk("R6 magnitude held", int'(err_mag), last_mag);
            end
        end
        sync_pulse = 1'b1;
        @(negedge clk);
        d    = r_prev - n;
        emag = (d >= 0) ? d : ((-d > MAX) ? MAX : -d);
        chk("R6 valid strobe", int'(err_valid), 1);
        if (d > 0)       chk("R3 slow magnitude", int'(err_mag), emag);
        else if (d < 0)  chk("R4 fast magnitude", int'(err_mag), emag);
        else             chk("R5 match magnitude", int'(err_mag), 0);
        chk("R4 fast flag", int'(err_fast), (d < 0) ? 1 : 0);
        chk("R5 match flag", int'(err_match), (d == 0) ? 1 : 0);
        chk("R10 warn flag", int'(err_warn), (emag > lim) ? 1 : 0);
        last_mag  = emag;
        have_last = 1;
        r_prev    = int'(reload_val);
    endtask

    initial begin
        int rl [5] = '{0, 3, 17, 64, 200};
        repeat (3) @(negedge clk);
        chk("R1 mag after reset", int'(err_mag), 0);
        chk("R1 valid after reset", int'(err_valid), 0);
        chk("R1 miss after reset", int'(miss_flag), 0);
        rst = 1'b0;
        reload_val = W'(5);
        @(negedge clk);
        sync_pulse = 1'b1;
        @(negedge clk);
        chk("R2 no strobe on arming pulse", int'(err_valid), 0);
        r_prev = 5;
        measure(5, 0);
        foreach (rl[k]) begin
            reload_val = W'(rl[k]);
            measure(3, 1); // R7: still uses previously loaded reload
            for (int n = 1; n <= rl[k] + 20; n++)
                measure(n, (n * 3) % 23);
        end
        sync_pulse = 1'b0;
        @(negedge clk);
        chk("R6 strobe single cycle", int'(err_valid), 0);
        chk("R9 no miss without saturation", int'(miss_flag), 0);
        sync_pulse = 1'b1;
        reload_val = W'(10);
        @(negedge clk);
        r_prev = 10;
        have_last = 0;
        measure(10 + MAX + 3, 7);
        chk("R8 saturated magnitude", int'(err_mag), MAX);
        chk("R9 miss set", int'(miss_flag), 1);
        measure(4, 7);
        chk("R9 miss sticky", int'(miss_flag), 1);
        sync_pulse = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 miss cleared", int'(miss_flag), 0);
        chk("R1 valid cleared", int'(err_valid), 0);
        chk("R1 fast cleared", int'(err_fast), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule